// File: doc/BRIEF.md
# Auto-Reload Countdown Interrupt Timer

This block is a periodic countdown timer with a small register-style control set: an 8-bit preset, a run bit, an interrupt-enable bit and a sticky event flag. The flag can be read and cleared. While the run bit is set, the counter steps down once for every source-clock tick enable. When a tick takes the count from 1 to 0, the timer signals an event. On that event it reloads the preset by itself and keeps counting, so events repeat every preset ticks with no software action.

Each event sets the flag, which stays set until software clears it. If interrupts are enabled at the moment of the event, the block also asserts an open-drain active-low interrupt. This is modelled as a drive-low enable that stays high for a fixed number of system clock cycles and then releases by itself. The pulse does not depend on the flag, and the flag survives stopping the timer.

Top module: `art_timer`

## Requirements
- R1: After reset, count_o, flag_o, run_o, irq_en_o, preset_o and irq_drive_o are all 0.
- R2: A write that takes run_o from 0 to 1 loads the held preset into the counter, so count_o equals preset_o in the next cycle.
- R3: While running, each cycle with tick_i high lowers count_o by 1 unless an event occurs. Cycles without tick_i leave count_o unchanged.
- R4: An event occurs only on a tick while count_o is 01h. On that tick the counter reloads preset_o instead of going to 0, so events repeat every preset_o ticks.
- R5: A preset of 00h gives a period of 256 ticks. The count goes from 00h to FFh on the first tick, and the event comes on the 256th tick.
- R6: An event sets flag_o in the next cycle, and flag_o stays 1 until flag_clr_i is pulsed. When a clear and an event fall in the same cycle, flag_o ends up 1.
- R7: When run_o is 0, ticks change neither count_o nor flag_o and raise no interrupt. A flag that was set before stopping stays 1.
- R8: If irq_en_o is 1 at an event, irq_drive_o is 1 for exactly RTN_CYC cycles, starting in the cycle after the event tick. If irq_en_o is 0, irq_drive_o stays 0.
- R9: Clearing the flag during a pulse does not shorten the pulse. The pulse ends after RTN_CYC cycles even when flag_o is still 1.
- R10: A later event drives irq_drive_o again without the flag being cleared. An event during a pulse restarts a full RTN_CYC-cycle pulse.
- R11: Preset writes are accepted only while run_o is 0. While running, preset_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Source-clock tick enable, one cycle per count step |
| preset_we_i | input | 1 | Preset write strobe |
| preset_i | input | CNT_W | Preset write data |
| run_we_i | input | 1 | Run bit write strobe |
| run_i | input | 1 | Run bit write data |
| irq_en_we_i | input | 1 | Interrupt-enable write strobe |
| irq_en_i | input | 1 | Interrupt-enable write data |
| flag_clr_i | input | 1 | Clear strobe for the sticky flag |
| preset_o | output | CNT_W | Held preset value |
| run_o | output | 1 | Run bit |
| irq_en_o | output | 1 | Interrupt-enable bit |
| flag_o | output | 1 | Sticky event flag |
| count_o | output | CNT_W | Current counter value |
| irq_drive_o | output | 1 | Open-drain drive-low enable for the interrupt line |

## Verification
The hardest case to reach is an event that lands while a pulse is still running. Reaching it needs a tick at the exact count of 01h within RTN_CYC cycles of the previous event. The bench sets the preset to 1, so every tick is an event, and places the second tick a few cycles into the first pulse. It then counts a full fresh pulse length. The flag clear that coincides with an event is set up the same way, with the preset at 1 and the clear strobe driven on the tick cycle.

// File: rtl/art_pkg.sv
package art_pkg;
  typedef struct packed {
    logic run;
    logic irq_en;
  } art_ctl_t;
endpackage

// File: rtl/art_counter.sv
module art_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] count_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             step;

  assign step  = run_i & tick_i & ~load_i;
  assign evt_o = step & (count_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (load_i)  count_q <= preset_i;
    else if (step)    count_q <= evt_o ? preset_i : count_q - ONE;
  end

  assign count_o = count_q;

  // R3: idle cycles hold the count
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(run_i && tick_i)) |=> $stable(count_q));
  // R3: a plain tick steps down by one
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && count_q != ONE) |=> count_q == $past(count_q) - ONE);
  // R4: the event tick reloads the preset
  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> count_q == $past(preset_i));
endmodule

// File: rtl/art_flag.sv
module art_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (evt_i) flag_q <= 1'b1;  // event beats clear
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6: set on every event, even with a clear pending
  a_r6_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_q);
  // R6: sticky without a clear
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/art_pulse.sv
module art_pulse #(
  parameter int unsigned RTN_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic irq_en_i,
  output logic drive_o
);
  localparam int unsigned PW = $clog2(RTN_CYC + 1);
  localparam logic [PW-1:0] LEN = PW'(RTN_CYC);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                left_q <= '0;
    else if (evt_i && irq_en_i) left_q <= LEN;  // retrigger restarts
    else if (left_q != '0)      left_q <= left_q - ONE;
  end

  assign drive_o = (left_q != '0);

  // R8: enabled event starts a pulse
  a_r8_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && irq_en_i) |=> drive_o);
  // R9: pulse only ends when its time is spent
  a_r9_full_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_o) |-> $past(left_q) == ONE);
  // R8: no pulse appears without an enabled event
  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drive_o && !(evt_i && irq_en_i)) |=> !drive_o);
endmodule

// File: rtl/art_timer.sv
module art_timer
  import art_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RTN_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             preset_we_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             run_we_i,
  input  logic             run_i,
  input  logic             irq_en_we_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] preset_o,
  output logic             run_o,
  output logic             irq_en_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_drive_o
);
  art_ctl_t         ctl_q;
  logic [CNT_W-1:0] preset_q;
  logic             start;
  logic             evt;

  assign start = run_we_i & run_i & ~ctl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= '0;
      preset_q <= '0;
    end else begin
      if (preset_we_i && !ctl_q.run) preset_q     <= preset_i;
      if (run_we_i)                  ctl_q.run    <= run_i;
      if (irq_en_we_i)               ctl_q.irq_en <= irq_en_i;
    end
  end

  art_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctl_q.run),
    .tick_i   (tick_i),
    .load_i   (start),
    .preset_i (preset_q),
    .count_o  (count_o),
    .evt_o    (evt)
  );

  art_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  art_pulse #(.RTN_CYC(RTN_CYC)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .irq_en_i (ctl_q.irq_en),
    .drive_o  (irq_drive_o)
  );

  assign preset_o = preset_q;
  assign run_o    = ctl_q.run;
  assign irq_en_o = ctl_q.irq_en;

  // R11: preset locked while running
  a_r11_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.run |=> $stable(preset_q));
  // R2: start loads the held preset
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> count_o == $past(preset_q));
  // R7: stopped timer raises no event
  a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q.run |-> !evt);
endmodule

// File: tb/art_timer_tb.sv
module art_timer_tb;
  localparam int CLK_P = 10;
  localparam int CW    = 8;
  localparam int TRTN  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, preset_we = 1'b0, run_we = 1'b0, run_d = 1'b0;
  logic          ie_we = 1'b0, ie_d = 1'b0, clr = 1'b0;
  logic [CW-1:0] preset_d = '0;
  logic [CW-1:0] preset_q, count;
  logic          run_q, ie_q, flag, drv;
  int            n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  art_timer #(.CNT_W(CW), .RTN_CYC(TRTN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .preset_we_i(preset_we), .preset_i(preset_d),
    .run_we_i(run_we), .run_i(run_d),
    .irq_en_we_i(ie_we), .irq_en_i(ie_d), .flag_clr_i(clr),
    .preset_o(preset_q), .run_o(run_q), .irq_en_o(ie_q),
    .flag_o(flag), .count_o(count), .irq_drive_o(drv)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic wr_preset(input int v);
    preset_we = 1'b1; preset_d = CW'(v); step(); preset_we = 1'b0;
  endtask
  task automatic set_run(input bit b);
    run_we = 1'b1; run_d = b; step(); run_we = 1'b0;
  endtask
  task automatic set_ie(input bit b);
    ie_we = 1'b1; ie_d = b; step(); ie_we = 1'b0;
  endtask
  task automatic do_tick(); tick = 1'b1; step(); tick = 1'b0; endtask
  task automatic clr_flag(); clr = 1'b1; step(); clr = 1'b0; endtask
  task automatic restart(input int p, input bit ie);
    set_run(0); clr_flag(); wr_preset(p); set_ie(ie); set_run(1);
  endtask
  // called just after the event tick; checks a full pulse then release
  task automatic chk_pulse(input string req);
    for (int i = 0; i < TRTN; i++) begin
      if (i > 0) step();
      chk(req, drv, 1);
    end
    step();
    chk(req, drv, 0);
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0); chk("R1 flag", flag, 0);
    chk("R1 run", run_q, 0);   chk("R1 ie", ie_q, 0);
    chk("R1 preset", preset_q, 0); chk("R1 irq", drv, 0);
  endtask

  task automatic t_load_count();
    restart(5, 0);
    chk("R2 load", count, 5);
    step(); step();
    chk("R3 no tick hold", count, 5);
    do_tick();
    chk("R3 decrement", count, 4);
  endtask

  task automatic t_period();
    restart(3, 1);
    do_tick(); chk("R4 count", count, 2); chk("R4 no early evt", flag, 0);
    do_tick(); chk("R4 count", count, 1); chk("R8 no early irq", drv, 0);
    do_tick();
    chk("R4 reload", count, 3); chk("R6 flag set", flag, 1);
    chk_pulse("R8 pulse length");
    chk("R9 flag still set after release", flag, 1);
    do_tick(); do_tick(); do_tick();
    chk("R6 flag kept", flag, 1);
    chk_pulse("R10 second pulse without clear");
  endtask

  task automatic t_clr_in_pulse();
    restart(1, 1);
    do_tick();
    chk("R9 irq", drv, 1);
    clr_flag();
    chk("R9 flag cleared", flag, 0);
    for (int i = 2; i <= TRTN; i++) begin
      chk("R9 pulse held after clear", drv, 1);
      if (i < TRTN) step();
    end
    step();
    chk("R9 release", drv, 0);
  endtask

  task automatic t_retrigger();
    restart(1, 1);
    do_tick();
    step(); step(); step();
    do_tick();
    chk_pulse("R10 retrigger full length");
  endtask

  task automatic t_clr_vs_evt();
    restart(1, 0);
    do_tick();
    chk("R6 set", flag, 1);
    clr = 1'b1; tick = 1'b1; step(); clr = 1'b0; tick = 1'b0;
    chk("R6 event beats clear", flag, 1);
    clr_flag();
    chk("R6 clear", flag, 0);
  endtask

  task automatic t_ie_off();
    restart(2, 0);
    do_tick(); do_tick();
    chk("R8 flag with ie off", flag, 1);
    for (int i = 0; i < TRTN + 2; i++) begin
      chk("R8 no irq with ie off", drv, 0);
      step();
    end
  endtask

  task automatic t_stop();
    restart(2, 1);
    do_tick(); do_tick();
    step(); step(); step(); step(); step(); step(); step(); step(); step();
    chk("R7 flag before stop", flag, 1);
    do_tick();
    chk("R7 count before stop", count, 1);
    set_run(0);
    for (int i = 0; i < 5; i++) do_tick();
    chk("R7 count held", count, 1);
    chk("R7 flag kept", flag, 1);
    clr_flag();
    for (int i = 0; i < 3; i++) do_tick();
    chk("R7 no event when stopped", flag, 0);
    chk("R7 no irq when stopped", drv, 0);
  endtask

  task automatic t_preset_lock();
    restart(4, 0);
    wr_preset(9);
    chk("R11 locked while running", preset_q, 4);
    set_run(0);
    wr_preset(9);
    chk("R11 write when stopped", preset_q, 9);
  endtask

  task automatic t_zero_preset();
    restart(0, 0);
    chk("R5 load zero", count, 0);
    do_tick();
    chk("R5 wrap", count, 255);
    for (int i = 0; i < 254; i++) do_tick();
    chk("R5 count at 255 ticks", count, 1);
    chk("R5 no event yet", flag, 0);
    do_tick();
    chk("R5 event on 256th", flag, 1);
    chk("R5 reload zero", count, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_load_count();
    t_period();
    t_clr_in_pulse();
    t_retrigger();
    t_clr_vs_evt();
    t_ie_off();
    t_stop();
    t_preset_lock();
    t_zero_preset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule